// File: doc/BRIEF.md
# Gated Dual Selectable Clock Divider

This block derives two slower clocks from one input clock. Output A runs at one half or one quarter of the input rate, and output B runs at one quarter or one sixth. Each output has its own select bit. Both outputs are built from counters that step on the same input edges. Any edge that the two outputs have in common therefore lands on the same input edge. The counters share a twelve-cycle frame, which is the least common multiple of all four ratios. A select change is picked up only at the start of a frame, so no output period is ever cut short.

An active-low enable gates the dividers. It is captured on the falling input edge, which means an enable change only takes effect while the internal gated clock is low. While the block is disabled, the counters freeze and both outputs stay low. Counting then picks up from where it stopped. An asynchronous active-low master reset clears every stage. Several instances released from the same reset therefore run in lockstep.

Top module: `cdiv_dual`

## Requirements
- R1: While rst_ni is low, both outputs are low and every counter, the frame position and the latched selects are cleared. Reset acts at once, with no clock edge needed.
- R2: Output A repeats every 2 input cycles when sel_a_i is 0 and every 4 input cycles when sel_a_i is 1.
- R3: Output B repeats every 4 input cycles when sel_b_i is 0 and every 6 input cycles when sel_b_i is 1.
- R4: Each output is high for exactly the first half of its period and low for the second half. For example, ratio 6 gives 3 cycles high and 3 cycles low.
- R5: Both counters advance on the same enabled rising edges of a shared 12-cycle frame. At each frame start, including the first enabled edge after reset, both outputs rise on the same input edge.
- R6: en_ni is active low and is sampled on the falling input edge. The level present at a falling edge decides whether the next rising edge advances the dividers. A change made after a falling edge waits for the next falling edge.
- R7: On a rising edge where the sampled enable is inactive, both outputs go low and all counters and the frame position hold their values. After re-enable, counting continues from the held phase.
- R8: Under any pattern of enable toggling, no high pulse on either output is shorter than one input period.
- R9: The select inputs are sampled only on the enabled edge at frame position 0, when all counters are at zero. A select change at any other time has no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| en_ni | input | 1 | Common enable, active low, sampled on the falling edge |
| sel_a_i | input | 1 | Output A ratio select: 0 gives 2, 1 gives 4 |
| sel_b_i | input | 1 | Output B ratio select: 0 gives 4, 1 gives 6 |
| clk_a_o | output | 1 | Divided clock A |
| clk_b_o | output | 1 | Divided clock B |

## Verification
The hardest case to reach is an enable change that lands right after a falling edge, at a point in the frame where a select change is also pending. Only a late change like this shows whether capture really happens on the falling edge, and whether frozen phases resume correctly. The stimulus drives enable either just after a rising edge or just after a falling edge, picking the timing at random per cycle. It also changes the selects at random within the frame. A scoreboard model predicts every output cycle, and timing monitors measure the width of every high pulse.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  function automatic int gcd(input int a, input int b);
    int x, y, t;
    x = a; y = b;
    while (y != 0) begin
      t = x % y; x = y; y = t;
    end
    return x;
  endfunction

  function automatic int lcm(input int a, input int b);
    return (a / gcd(a, b)) * b;
  endfunction
endpackage

// File: rtl/cdiv_en_sync.sv
`timescale 1ns/1ps
module cdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  // captured while clk_i falls, so gating changes only with the gated clock low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= 1'b0;
    else         run_o <= ~en_ni;
  end
endmodule

// File: rtl/cdiv_frame.sv
`timescale 1ns/1ps
module cdiv_frame #(
  parameter int FRAME = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic zero_o
);
  localparam int FW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAME - 1);

  logic [FW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (run_i) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign zero_o = (pos_q == '0);
endmodule

// File: rtl/cdiv_stage.sv
`timescale 1ns/1ps
module cdiv_stage #(
  parameter int RATIO_LO = 2,
  parameter int RATIO_HI = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  input  logic sel_i,
  output logic clk_o
);
  localparam int W = $clog2(RATIO_HI + 1);

  logic         sel_q, sel_eff;
  logic [W-1:0] cnt_q, ratio, half;

  assign sel_eff = load_i ? sel_i : sel_q;
  assign ratio   = sel_eff ? W'(RATIO_HI) : W'(RATIO_LO);
  assign half    = ratio >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      clk_o <= 1'b0;
    end else if (run_i) begin
      if (load_i) sel_q <= sel_i;
      clk_o <= (cnt_q < half);
      cnt_q <= (cnt_q == ratio - 1'b1) ? '0 : cnt_q + 1'b1;
    end else begin
      clk_o <= 1'b0;
    end
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q) && !clk_o);

  a_r9_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && load_i) |=> $stable(sel_q));

  a_r9_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && load_i) |-> (cnt_q == '0));
endmodule

// File: rtl/cdiv_dual.sv
`timescale 1ns/1ps
module cdiv_dual #(
  parameter int A_LO = 2,
  parameter int A_HI = 4,
  parameter int B_LO = 4,
  parameter int B_HI = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  input  logic sel_a_i,
  input  logic sel_b_i,
  output logic clk_a_o,
  output logic clk_b_o
);
  import cdiv_pkg::*;

  localparam int FRAME = lcm(lcm(A_LO, A_HI), lcm(B_LO, B_HI));
  localparam int NOUT  = 2;

  logic            run, frame_zero;
  logic [NOUT-1:0] sel, div_clk;

  assign sel = {sel_b_i, sel_a_i};

  cdiv_en_sync u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_ni),
    .run_o (run)
  );

  cdiv_frame #(.FRAME(FRAME)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .zero_o(frame_zero)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_stage
    cdiv_stage #(
      .RATIO_LO((i == 0) ? A_LO : B_LO),
      .RATIO_HI((i == 0) ? A_HI : B_HI)
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .load_i(frame_zero),
      .sel_i (sel[i]),
      .clk_o (div_clk[i])
    );
  end

  assign clk_a_o = div_clk[0];
  assign clk_b_o = div_clk[1];

  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_a_o && !clk_b_o));

  a_r5_frame_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && frame_zero) |=> (clk_a_o && clk_b_o));
endmodule

// File: tb/cdiv_dual_bench.sv
`timescale 1ns/1ps
module cdiv_dual_bench;
  localparam real CYC = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en_n = 1'b0;
  logic sel_a = 1'b0;
  logic sel_b = 1'b0;
  logic clk_a, clk_b;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int    cyc;
    bit    a;
    bit    b;
    string req;
  } exp_t;

  exp_t  q[$];
  string cur_req = "R1";
  int    ph = 0;
  bit    sa_m = 1'b0, sb_m = 1'b0;
  bit    done = 1'b0;

  cdiv_dual u_cdiv_dual (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_ni  (en_n),
    .sel_a_i(sel_a),
    .sel_b_i(sel_b),
    .clk_a_o(clk_a),
    .clk_b_o(clk_b)
  );

  initial forever #(CYC/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: got %0b exp %0b", req, what, cyc, got, exp);
    end
  endtask

  // reference model: frame position, latched selects, expected levels after next edge
  task automatic push_exp(input bit run);
    exp_t e;
    int na, nb;
    e.cyc = cyc + 1;
    e.req = cur_req;
    if (run) begin
      if (ph == 0) begin
        sa_m = sel_a;
        sb_m = sel_b;
      end
      na  = sa_m ? 4 : 2;
      nb  = sb_m ? 6 : 4;
      e.a = (ph % na) < (na / 2);
      e.b = (ph % nb) < (nb / 2);
      ph  = (ph + 1) % 12;
    end else begin
      e.a = 1'b0;
      e.b = 1'b0;
    end
    q.push_back(e);
  endtask

  // late=1 drives enable after the falling edge of this cycle
  task automatic step(input bit en_v, input bit sa, input bit sb, input bit late);
    @(posedge clk);
    #0.5;
    sel_a = sa;
    sel_b = sb;
    if (!late) en_n = en_v;
    push_exp(!en_n);
    if (late) begin
      #2;
      en_n = en_v;
    end
  endtask

  task automatic do_reset(input int n);
    @(posedge clk);
    #0.5;
    rst_n = 1'b0;
    q.delete();
    ph = 0; sa_m = 1'b0; sb_m = 1'b0;
    #0.1;
    check("R1", "async clk_a", clk_a, 1'b0);
    check("R1", "async clk_b", clk_b, 1'b0);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check("R1", "held clk_a", clk_a, 1'b0);
      check("R1", "held clk_b", clk_b, 1'b0);
    end
    @(posedge clk);
    #0.5;
    rst_n = 1'b1;
    push_exp(!en_n);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc < cyc) void'(q.pop_front());
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "clk_a", clk_a, e.a);
        check(e.req, "clk_b", clk_b, e.b);
      end
    end
  end

  // R8: high pulse width monitors
  realtime ta = 0.0, tb = 0.0;
  always @(posedge clk_a) ta = $realtime;
  always @(posedge clk_b) tb = $realtime;
  always @(negedge clk_a) if (rst_n === 1'b1 && !done) begin
    checks++;
    if ($realtime - ta < CYC - 0.01) begin
      fails++;
      $display("FAIL R8 clk_a high width %0.3f exp >= %0.3f", $realtime - ta, CYC);
    end
  end
  always @(negedge clk_b) if (rst_n === 1'b1 && !done) begin
    checks++;
    if ($realtime - tb < CYC - 0.01) begin
      fails++;
      $display("FAIL R8 clk_b high width %0.3f exp >= %0.3f", $realtime - tb, CYC);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CYC * 200000.0);
    fails++;
    checks++;
    $display("FAIL watchdog expired: got hang exp completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    cur_req = "R1";
    do_reset(3);

    cur_req = "R5";
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    cur_req = "R4";
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b0, 1'b0);

    cur_req = "R9";
    for (int i = 0; i < 48; i++) step(1'b0, (i % 5) == 2, (i % 7) == 3, 1'b0);

    cur_req = "R7";
    for (int i = 0; i < 5; i++)  step(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++)  step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, 1'b0);

    cur_req = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 1'b1);

    cur_req = "R8";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);

    cur_req = "R1";
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    do_reset(2);
    cur_req = "R5";
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b1, 1'b0);

    @(posedge clk);
    @(posedge clk);
    #1;
    finish_run();
  end
endmodule